// File: doc/BRIEF.md
# I2C SCL Phase Timer

This block paces the clock line of an I2C master. Four counts, all in input-clock cycles, set the timing: the full SCL period, the part of it that SCL is held low, the setup and hold time around START and STOP conditions, and the lead time by which SDA must change before SCL is released. The counts are usually derived from one figure, the input clock rate divided by the bus rate. The bus rate is nonzero and at most 400 kHz, with 100 kHz as the usual setting. The low count is then about 5/9 of the period, so low and high stand in a 5:4 ratio. The condition count is half the period and the data lead is a sixteenth of it.

While a transfer request is held, the timer produces single-cycle strobes for the byte engine. One marks a completed START or STOP setup. One tells the engine to change SDA. One marks the release of SCL, and one marks the point at which SDA should be sampled. The counts are captured when a transfer starts, so firmware can load new values at any time.

For bus recovery, clearing the timing-enable input stops the sequence and places SCL under direct control of a manual release input. A four-bit monitor word reports the synchronised line levels together with the levels being driven.

Top module: `i2c_scl_timer`

## Requirements
- R1: After reset, `scl_out` is 1 (released) and all four strobes are 0.
- R2: With `timing_en` high, the edge that first sees `xfer_run` high in idle starts a START setup in which SCL stays high. Exactly C edges later (C = `cnt_cond`), `stb_cond_done` pulses for one cycle in the same cycle that `scl_out` first goes to 0.
- R3: Each low phase lasts L cycles (L = `cnt_low`). After it, `scl_out` returns to 1 and `stb_scl_rise` pulses for one cycle in that first high cycle.
- R4: `stb_sda_change` pulses once per low phase, while `scl_out` is 0, exactly D cycles before `stb_scl_rise` (D = `cnt_dsetup`, with 1 <= D < L).
- R5: Each high phase lasts H = P - L cycles (P = `cnt_period`), so successive low phases start P cycles apart. `stb_sda_sample` pulses in high cycle floor(H/2)+1.
- R6: If `xfer_run` is low at the end of a high phase, SCL stays high for C more cycles. `stb_cond_done` then pulses once and the timer returns to idle with no further strobes.
- R7: All four counts are captured on the edge that leaves idle. Changes to them before the return to idle do not alter the strobe timing of the transfer in progress.
- R8: While `timing_en` is low, the timer stays idle and issues no strobes, and `scl_out` equals the value of `scl_release_man` at the previous edge, even with `xfer_run` high.
- R9: `line_mon` bit 3 is the SCL line, bit 2 is `scl_out`, bit 1 is the SDA line and bit 0 is `sda_drive`. Each bit passes through SYNC_STAGES register stages.
- R10: At most one strobe is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_run | input | 1 | Byte engine requests SCL cycles; dropping it ends with a STOP setup |
| timing_en | input | 1 | 1 = timed operation, 0 = manual SCL control |
| scl_release_man | input | 1 | Manual SCL level used while timing_en is 0 (1 = release) |
| cnt_period | input | CNT_W | Full SCL period P in cycles |
| cnt_low | input | CNT_W | SCL low time L in cycles |
| cnt_cond | input | CNT_W | START/STOP setup and hold time C in cycles |
| cnt_dsetup | input | CNT_W | SDA lead D before SCL rises |
| scl_line | input | 1 | Sensed SCL level |
| sda_line | input | 1 | Sensed SDA level |
| sda_drive | input | 1 | SDA level the byte engine is driving |
| scl_out | output | 1 | SCL drive (1 = released, 0 = pull low) |
| stb_sda_change | output | 1 | Strobe: change SDA now |
| stb_scl_rise | output | 1 | Strobe: SCL released this cycle |
| stb_sda_sample | output | 1 | Strobe: sample SDA now |
| stb_cond_done | output | 1 | Strobe: START or STOP setup complete |
| line_mon | output | 4 | Synchronised line and drive readback |

## Verification
The properties assume that the captured counts are consistent: C >= 1, 1 <= D < L, and P - L >= 2. Under those limits the change, rise and sample strobes always fall in distinct cycles of the correct SCL level. The stimulus only ever programs count sets that meet these limits, including the replacement set written in the middle of a transfer. It drops `xfer_run` only during the last high phase of a transfer, so every transfer ends with a full STOP setup.

// File: rtl/i2c_scl_pkg.sv
package i2c_scl_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_LOW,
        PH_HIGH,
        PH_STOP
    } phase_e;

    typedef struct packed {
        logic cond;
        logic change;
        logic rise;
        logic sample;
    } strobe_t;

endpackage

// File: rtl/i2c_scl_cfg_snap.sv
// Captures the four counts while idle and pre-computes derived limits.
module i2c_scl_cfg_snap #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] per_i,
    input  logic [CNT_W-1:0] low_i,
    input  logic [CNT_W-1:0] cond_i,
    input  logic [CNT_W-1:0] dset_i,
    output logic [CNT_W-1:0] low_o,
    output logic [CNT_W-1:0] high_o,
    output logic [CNT_W-1:0] cond_o,
    output logic [CNT_W-1:0] chg_at_o,
    output logic [CNT_W-1:0] smp_at_o
);
    typedef struct packed {
        logic [CNT_W-1:0] low;
        logic [CNT_W-1:0] high;
        logic [CNT_W-1:0] cond;
        logic [CNT_W-1:0] chg_at;
        logic [CNT_W-1:0] smp_at;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic [CNT_W-1:0] high_w;

    always_comb begin
        high_w = per_i - low_i;
        cfg_d  = cfg_q;
        if (load) begin
            cfg_d.low    = low_i;
            cfg_d.high   = high_w;
            cfg_d.cond   = cond_i;
            cfg_d.chg_at = low_i - dset_i;
            cfg_d.smp_at = high_w >> 1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign low_o    = cfg_q.low;
    assign high_o   = cfg_q.high;
    assign cond_o   = cfg_q.cond;
    assign chg_at_o = cfg_q.chg_at;
    assign smp_at_o = cfg_q.smp_at;
endmodule

// File: rtl/i2c_scl_phase.sv
// Phase sequencer: START setup, low/high SCL phases, STOP setup.
module i2c_scl_phase
    import i2c_scl_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             en_i,
    input  logic             man_i,
    input  logic [CNT_W-1:0] low_i,
    input  logic [CNT_W-1:0] high_i,
    input  logic [CNT_W-1:0] cond_i,
    input  logic [CNT_W-1:0] chg_at_i,
    input  logic [CNT_W-1:0] smp_at_i,
    output logic             idle_o,
    output logic             scl_o,
    output strobe_t          strb_o
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        phase_e           ph;
        logic [CNT_W-1:0] cnt;
        logic             scl;
        strobe_t          strb;
    } seq_t;

    seq_t s_d, s_q;
    logic [CNT_W-1:0] cnt_inc;

    always_comb begin
        cnt_inc = s_q.cnt + CNT_ONE;
        s_d      = s_q;
        s_d.strb = '0;
        if (!en_i) begin
            s_d.ph  = PH_IDLE;
            s_d.cnt = CNT_ONE;
            s_d.scl = man_i;
        end else begin
            unique case (s_q.ph)
                PH_IDLE: begin
                    s_d.scl = 1'b1;
                    s_d.cnt = CNT_ONE;
                    if (run_i) s_d.ph = PH_START;
                end
                PH_START: begin
                    if (s_q.cnt >= cond_i) begin
                        s_d.ph        = PH_LOW;
                        s_d.cnt       = CNT_ONE;
                        s_d.scl       = 1'b0;
                        s_d.strb.cond = 1'b1;
                    end else begin
                        s_d.cnt = cnt_inc;
                    end
                end
                PH_LOW: begin
                    if (s_q.cnt == chg_at_i) s_d.strb.change = 1'b1;
                    if (s_q.cnt >= low_i) begin
                        s_d.ph        = PH_HIGH;
                        s_d.cnt       = CNT_ONE;
                        s_d.scl       = 1'b1;
                        s_d.strb.rise = 1'b1;
                    end else begin
                        s_d.cnt = cnt_inc;
                    end
                end
                PH_HIGH: begin
                    if (s_q.cnt == smp_at_i) s_d.strb.sample = 1'b1;
                    if (s_q.cnt >= high_i) begin
                        s_d.cnt = CNT_ONE;
                        if (run_i) begin
                            s_d.ph  = PH_LOW;
                            s_d.scl = 1'b0;
                        end else begin
                            s_d.ph = PH_STOP;
                        end
                    end else begin
                        s_d.cnt = cnt_inc;
                    end
                end
                PH_STOP: begin
                    if (s_q.cnt >= cond_i) begin
                        s_d.ph        = PH_IDLE;
                        s_d.cnt       = CNT_ONE;
                        s_d.strb.cond = 1'b1;
                    end else begin
                        s_d.cnt = cnt_inc;
                    end
                end
                default: begin
                    s_d.ph  = PH_IDLE;
                    s_d.scl = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.ph   <= PH_IDLE;
            s_q.cnt  <= CNT_ONE;
            s_q.scl  <= 1'b1;
            s_q.strb <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign idle_o = (s_q.ph == PH_IDLE);
    assign scl_o  = s_q.scl;
    assign strb_o = s_q.strb;
endmodule

// File: rtl/i2c_line_sync.sv
// Multi-stage register chain for the line monitor word.
module i2c_line_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] chain_d [STAGES];
    logic [W-1:0] chain_q [STAGES];

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_head
                always_comb chain_d[g] = d_i;
            end else begin : g_tail
                always_comb chain_d[g] = chain_q[g-1];
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[g] <= '0;
                else        chain_q[g] <= chain_d[g];
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/i2c_scl_timer.sv
module i2c_scl_timer
    import i2c_scl_pkg::*;
#(
    parameter int CNT_W       = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xfer_run,
    input  logic             timing_en,
    input  logic             scl_release_man,
    input  logic [CNT_W-1:0] cnt_period,
    input  logic [CNT_W-1:0] cnt_low,
    input  logic [CNT_W-1:0] cnt_cond,
    input  logic [CNT_W-1:0] cnt_dsetup,
    input  logic             scl_line,
    input  logic             sda_line,
    input  logic             sda_drive,
    output logic             scl_out,
    output logic             stb_sda_change,
    output logic             stb_scl_rise,
    output logic             stb_sda_sample,
    output logic             stb_cond_done,
    output logic [3:0]       line_mon
);
    localparam int MON_W = 4;

    logic             idle_w;
    logic [CNT_W-1:0] low_w, high_w, cond_w, chg_w, smp_w;
    strobe_t          strb_w;
    logic [MON_W-1:0] mon_raw;

    i2c_scl_cfg_snap #(.CNT_W(CNT_W)) u_snap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (idle_w),
        .per_i    (cnt_period),
        .low_i    (cnt_low),
        .cond_i   (cnt_cond),
        .dset_i   (cnt_dsetup),
        .low_o    (low_w),
        .high_o   (high_w),
        .cond_o   (cond_w),
        .chg_at_o (chg_w),
        .smp_at_o (smp_w)
    );

    i2c_scl_phase #(.CNT_W(CNT_W)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (xfer_run),
        .en_i     (timing_en),
        .man_i    (scl_release_man),
        .low_i    (low_w),
        .high_i   (high_w),
        .cond_i   (cond_w),
        .chg_at_i (chg_w),
        .smp_at_i (smp_w),
        .idle_o   (idle_w),
        .scl_o    (scl_out),
        .strb_o   (strb_w)
    );

    assign mon_raw = {scl_line, scl_out, sda_line, sda_drive};

    i2c_line_sync #(.W(MON_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (mon_raw),
        .q_o   (line_mon)
    );

    assign stb_cond_done  = strb_w.cond;
    assign stb_sda_change = strb_w.change;
    assign stb_scl_rise   = strb_w.rise;
    assign stb_sda_sample = strb_w.sample;
endmodule

// File: rtl/i2c_scl_timer_chk.sv
module i2c_scl_timer_chk (
    input logic clk,
    input logic rst_n,
    input logic timing_en,
    input logic scl_release_man,
    input logic scl_out,
    input logic stb_sda_change,
    input logic stb_scl_rise,
    input logic stb_sda_sample,
    input logic stb_cond_done
);
    logic armed_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    // R10
    strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({stb_cond_done, stb_sda_change, stb_scl_rise, stb_sda_sample}));

    // R3
    rise_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && stb_scl_rise) |-> (scl_out && !$past(scl_out)));

    // R4
    change_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stb_sda_change |-> !scl_out);

    // R5
    sample_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stb_sda_sample |-> scl_out);

    // R2
    start_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && stb_cond_done && !scl_out) |-> $past(scl_out));

    // R8
    man_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(!timing_en)) |-> (scl_out == $past(scl_release_man)));

    // R8
    man_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(!timing_en)) |->
        !(stb_cond_done || stb_sda_change || stb_scl_rise || stb_sda_sample));
endmodule

bind i2c_scl_timer i2c_scl_timer_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .timing_en       (timing_en),
    .scl_release_man (scl_release_man),
    .scl_out         (scl_out),
    .stb_sda_change  (stb_sda_change),
    .stb_scl_rise    (stb_scl_rise),
    .stb_sda_sample  (stb_sda_sample),
    .stb_cond_done   (stb_cond_done)
);

// File: tb/tb_i2c_scl_timer.sv
`timescale 1ns/1ps
module tb_i2c_scl_timer;
    localparam int CW = 12;

    logic clk = 1'b0, rst_n = 1'b0;
    logic xfer_run = 1'b0, timing_en = 1'b0, scl_release_man = 1'b1;
    logic [CW-1:0] cnt_period = 18, cnt_low = 10, cnt_cond = 9, cnt_dsetup = 1;
    logic scl_line = 1'b1, sda_line = 1'b1, sda_drive = 1'b1;
    logic scl_out, stb_sda_change, stb_scl_rise, stb_sda_sample, stb_cond_done;
    logic [3:0] line_mon;

    i2c_scl_timer #(.CNT_W(CW), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .xfer_run(xfer_run), .timing_en(timing_en),
        .scl_release_man(scl_release_man), .cnt_period(cnt_period),
        .cnt_low(cnt_low), .cnt_cond(cnt_cond), .cnt_dsetup(cnt_dsetup),
        .scl_line(scl_line), .sda_line(sda_line), .sda_drive(sda_drive),
        .scl_out(scl_out), .stb_sda_change(stb_sda_change),
        .stb_scl_rise(stb_scl_rise), .stb_sda_sample(stb_sda_sample),
        .stb_cond_done(stb_cond_done), .line_mon(line_mon)
    );

    always #2.5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int total = 0, bad = 0;
    string cur_req = "R1";

    typedef struct {
        int    kind;
        int    t;
        string req;
    } ev_t;
    ev_t exp_q[$];

    task automatic chk(bit ok, string req, string what, int act, int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic push(int k, int t, string r);
        ev_t e;
        e.kind = k; e.t = t; e.req = r;
        exp_q.push_back(e);
    endtask

    task automatic got(int k);
        ev_t e;
        total++;
        if (exp_q.size() == 0) begin
            bad++;
            $display("FAIL %s unexpected strobe kind=%0d at cycle %0d: actual=1 expected=0",
                     cur_req, k, cyc);
        end else begin
            e = exp_q.pop_front();
            if (e.kind != k || e.t != cyc) begin
                bad++;
                $display("FAIL %s strobe: actual kind=%0d cycle=%0d expected kind=%0d cycle=%0d",
                         e.req, k, cyc, e.kind, e.t);
            end
        end
    endtask

    // monitor: kinds 0=cond 1=change 2=rise 3=sample
    always @(negedge clk) begin
        if (rst_n) begin
            if (stb_cond_done) got(0);
            if (stb_sda_change) begin
                got(1);
                chk(scl_out == 1'b0, "R4", "scl level at change strobe", scl_out, 0);
            end
            if (stb_scl_rise) begin
                got(2);
                chk(scl_out == 1'b1, "R3", "scl level at rise strobe", scl_out, 1);
            end
            if (stb_sda_sample) got(3);
        end
    end

    task automatic wait_cyc(int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic run_xfer(int p, int l, int c, int d, int n, bit chg);
        int base, h;
        @(negedge clk);
        cnt_period = CW'(p); cnt_low = CW'(l); cnt_cond = CW'(c); cnt_dsetup = CW'(d);
        timing_en = 1'b1;
        xfer_run  = 1'b1;
        base = cyc + 1;
        h = p - l;
        push(0, base + c, "R2");
        for (int i = 0; i < n; i++) begin
            push(1, base + c + i*p + l - d, "R4");
            push(2, base + c + i*p + l, "R3");
            push(3, base + c + i*p + l + h/2 + 1 - 1, "R5");
        end
        push(0, base + c + n*p + c, "R6");
        wait_cyc(base + c);
        chk(scl_out == 1'b0, "R2", "scl after start setup", scl_out, 0);
        if (chg) begin
            // R7: new counts while busy must not change this transfer
            cnt_period = 40; cnt_low = 22; cnt_cond = 20; cnt_dsetup = 2;
        end
        wait_cyc(base + c + (n-1)*p + l + 1);
        xfer_run = 1'b0;
        wait_cyc(base + c + n*p + c + 4);
        chk(exp_q.size() == 0, cur_req, "missing strobes", exp_q.size(), 0);
        chk(scl_out == 1'b1, "R6", "scl released after stop", scl_out, 1);
    endtask

    bit done = 1'b0;

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(scl_out == 1'b1, "R1", "scl in reset", scl_out, 1);
        chk({stb_cond_done, stb_sda_change, stb_scl_rise, stb_sda_sample} == 4'b0,
            "R1", "strobes in reset",
            {stb_cond_done, stb_sda_change, stb_scl_rise, stb_sda_sample}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(scl_out == 1'b1, "R1", "scl after reset", scl_out, 1);

        // R2 R3 R4 R5 R6: 100 kHz style counts
        cur_req = "R5";
        run_xfer(18, 10, 9, 1, 2, 1'b0);
        run_xfer(36, 20, 18, 2, 3, 1'b0);
        run_xfer(9, 5, 4, 3, 4, 1'b0);

        // R7: counts rewritten mid transfer
        cur_req = "R7";
        run_xfer(12, 6, 6, 1, 3, 1'b1);
        run_xfer(18, 10, 9, 1, 1, 1'b0);

        // R8: abort into manual mode
        cur_req = "R8";
        @(negedge clk);
        cnt_period = 18; cnt_low = 10; cnt_cond = 9; cnt_dsetup = 1;
        timing_en = 1'b1; xfer_run = 1'b1;
        push(0, cyc + 1 + 9, "R2");
        wait_cyc(cyc + 1 + 9 + 3);
        timing_en = 1'b0; scl_release_man = 1'b1;
        @(negedge clk);
        chk(scl_out == 1'b1, "R8", "manual release", scl_out, 1);
        scl_release_man = 1'b0;
        @(negedge clk);
        chk(scl_out == 1'b0, "R8", "manual pull low", scl_out, 0);
        repeat (30) @(negedge clk);
        chk(scl_out == 1'b0, "R8", "manual hold low", scl_out, 0);
        scl_release_man = 1'b1;
        @(negedge clk);
        chk(scl_out == 1'b1, "R8", "manual release again", scl_out, 1);
        chk(exp_q.size() == 0, "R8", "pending strobes", exp_q.size(), 0);

        // R9: monitor readback, scl_out held at 1 by manual mode
        scl_line = 1'b0; sda_line = 1'b1; sda_drive = 1'b0;
        repeat (2) @(negedge clk);
        chk(line_mon == 4'b0110, "R9", "monitor word A", line_mon, 4'b0110);
        scl_line = 1'b1; sda_line = 1'b0; sda_drive = 1'b1;
        @(negedge clk);
        chk(line_mon == 4'b0110, "R9", "monitor latency", line_mon, 4'b0110);
        @(negedge clk);
        chk(line_mon == 4'b1101, "R9", "monitor word B", line_mon, 4'b1101);
        scl_release_man = 1'b0;
        repeat (3) @(negedge clk);
        chk(line_mon == 4'b1001, "R9", "monitor drive bit", line_mon, 4'b1001);

        // back to timed operation, no request: idle and quiet
        cur_req = "R6";
        xfer_run = 1'b0; timing_en = 1'b1;
        repeat (20) @(negedge clk);
        chk(scl_out == 1'b1, "R6", "idle release", scl_out, 1);
        chk(exp_q.size() == 0, "R10", "queue empty at end", exp_q.size(), 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule